// File: doc/BRIEF.md
# Same-ID Write Response Ordering Router

This block sits between one write-issuing master and two downstream targets. Each write address is steered to target port 0 or target port 1 by a single address bit. The block records two things. For each ID, it keeps the port that every outstanding write went to. Across all IDs, it keeps the order in which write addresses were accepted, so that data beats can be steered to the right port. The write data channel carries no ID, so it follows the accepted address order.

The two targets may finish writes in any order. Write responses go back to the master so that, for any single ID, they arrive in the same order the writes were issued. A response that comes back early from one port, while an older write with the same ID is still open on the other port, is parked: the block holds that port's ready low until the older response has been passed upstream. Responses with different IDs are independent of each other and may overtake. When both ports hold a deliverable response, the block alternates between them.

On the upstream side the block acts as a write target. On each downstream side it acts as a write initiator. The usual valid/ready rules hold on every one of these ports. Read traffic is not handled here.

Top module: `wr_order_router`

## Requirements
- R1: Address bit SEL_BIT (default 12) selects the target port: 0 selects port 0 and 1 selects port 1. Only the selected port sees `m_awvalid`, and ID, address and length are forwarded unchanged.
- R2: An ID may have at most DEPTH (default 4) writes whose responses have not yet been returned upstream. A further address with that ID is held off (`s_awready` low) until one of those responses has been delivered to the master.
- R3: Write data beats go to the port of the oldest accepted address whose burst has not yet finished. A beat with `s_wlast` high ends that burst. `s_wready` stays low and no `m_wvalid` is raised while no accepted address is waiting for data.
- R4: For one ID, responses reach the master in issue order, even when the writes went to different ports. A response from the port of the later write keeps that port's `m_bready` low until the earlier response has been delivered.
- R5: A response whose ID has no older outstanding write elsewhere is delivered even while a response for a different ID is still pending on the other port.
- R6: `s_bid` and `s_bresp` equal the ID and response code of the port whose response is being delivered.
- R7: When both ports hold a deliverable response in consecutive cycles, grants alternate between port 0 and port 1.
- R8: Once `s_bvalid` is raised, it stays high with `s_bid` and `s_bresp` unchanged until `s_bready` completes the handshake.
- R9: After reset, with idle inputs, `s_bvalid`, `s_awready`, `s_wready`, `m_awvalid`, `m_wvalid` and `m_bready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awid | input | ID_W | Write ID |
| s_awaddr | input | ADDR_W | Write start address |
| s_awlen | input | LEN_W | Beats in burst minus one |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wlast | input | 1 | Last beat of burst |
| s_bvalid | output | 1 | Upstream response valid |
| s_bready | input | 1 | Upstream response ready |
| s_bid | output | ID_W | Response ID |
| s_bresp | output | 2 | Response code |
| m_awvalid | output | 2 | Per-port write address valid |
| m_awready | input | 2 | Per-port write address ready |
| m_awid | output | ID_W | Forwarded write ID |
| m_awaddr | output | ADDR_W | Forwarded address |
| m_awlen | output | LEN_W | Forwarded burst length |
| m_wvalid | output | 2 | Per-port write data valid |
| m_wready | input | 2 | Per-port write data ready |
| m_wdata | output | DATA_W | Forwarded write data |
| m_wlast | output | 1 | Forwarded last-beat flag |
| m_bvalid | input | 2 | Per-port response valid |
| m_bready | output | 2 | Per-port response ready |
| m_bid | input | 2*ID_W | Per-port response ID, port k in bits [k*ID_W +: ID_W] |
| m_bresp | input | 4 | Per-port response code, port k in bits [2k +: 2] |

## Verification
The hardest case to reach is two ports presenting responses at the same moment in different orders. In one variant, port 1's same-ID response arrives before port 0's. In another, both ports have a fresh deliverable response in every cycle, so the round-robin choice decides each grant. The bench drives each downstream target from its own task. It issues writes to both ports and then forks the two targets. In one fork the later-issued port answers first while its ready is watched. In another, each port answers twice, back to back, with no gap, using two IDs per port. A per-ID scoreboard then checks which port each delivered response came from.

// File: rtl/wor_pkg.sv
`timescale 1ns/1ps
package wor_pkg;
  localparam int NPORT = 2;
  typedef logic [0:0] port_t;
endpackage

// File: rtl/wor_fifo.sv
`timescale 1ns/1ps
module wor_fifo #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/wor_w_router.sv
`timescale 1ns/1ps
module wor_w_router
  import wor_pkg::*;
#(
  parameter int RDEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aw_push,
  input  port_t            aw_port,
  output logic             route_full,
  input  logic             s_wvalid,
  input  logic             s_wlast,
  output logic             s_wready,
  output logic [NPORT-1:0] m_wvalid,
  input  logic [NPORT-1:0] m_wready
);
  logic  rt_empty;
  port_t rt_head;
  logic  burst_done;

  wor_fifo #(.WIDTH(1), .DEPTH(RDEPTH)) u_route (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (aw_push),
    .pop   (burst_done),
    .din   (aw_port),
    .head  (rt_head),
    .full  (route_full),
    .empty (rt_empty)
  );

  always_comb begin
    m_wvalid = '0;
    if (s_wvalid && !rt_empty) m_wvalid[rt_head] = 1'b1;
  end

  assign s_wready   = !rt_empty && m_wready[rt_head];
  assign burst_done = s_wvalid && s_wready && s_wlast;

  p_one_wport_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_wvalid));
  p_beat_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_wvalid && s_wready |-> |(m_wvalid & m_wready));
endmodule

// File: rtl/wor_b_arbiter.sv
`timescale 1ns/1ps
module wor_b_arbiter
  import wor_pkg::*;
#(
  parameter int ID_W = 2,
  localparam int NUM_ID = 1 << ID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   m_bvalid,
  output logic [NPORT-1:0]   m_bready,
  input  logic [2*ID_W-1:0]  m_bid,
  input  logic [3:0]         m_bresp,
  input  logic [NUM_ID-1:0]  id_head,
  input  logic [NUM_ID-1:0]  id_empty,
  output logic               s_bvalid,
  input  logic               s_bready,
  output logic [ID_W-1:0]    s_bid,
  output logic [1:0]         s_bresp,
  output logic               b_fire
);
  logic [NPORT-1:0] elig;
  port_t            pick;
  logic             lock_q, lock_d;
  port_t            lock_sel_q, lock_sel_d;
  port_t            prio_q, prio_d;

  for (genvar k = 0; k < NPORT; k++) begin : g_elig
    logic [ID_W-1:0] bid_k;
    assign bid_k   = m_bid[k*ID_W +: ID_W];
    assign elig[k] = m_bvalid[k] && !id_empty[bid_k] && (id_head[bid_k] == 1'(k));
  end

  always_comb begin
    if (lock_q)     pick = lock_sel_q;
    else if (&elig) pick = prio_q;
    else            pick = elig[1];
  end

  assign s_bvalid = elig[pick];
  assign b_fire   = s_bvalid && s_bready;
  assign s_bid    = pick[0] ? m_bid[2*ID_W-1:ID_W] : m_bid[ID_W-1:0];
  assign s_bresp  = pick[0] ? m_bresp[3:2] : m_bresp[1:0];

  always_comb begin
    m_bready       = '0;
    m_bready[pick] = b_fire;
  end

  always_comb begin
    lock_d     = lock_q;
    lock_sel_d = lock_sel_q;
    prio_d     = prio_q;
    if (b_fire) begin
      lock_d = 1'b0;
      prio_d = ~pick;
    end else if (s_bvalid) begin
      lock_d     = 1'b1;
      lock_sel_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_sel_q <= '0;
      prio_q     <= '0;
    end else begin
      lock_q     <= lock_d;
      lock_sel_q <= lock_sel_d;
      prio_q     <= prio_d;
    end
  end

  p_bready_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_bready) && ((m_bready & ~m_bvalid) == '0));
  p_bvalid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bid) && $stable(s_bresp));
  p_bid_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_fire && m_bready[1] |-> s_bid == m_bid[2*ID_W-1:ID_W]);
endmodule

// File: rtl/wr_order_router.sv
`timescale 1ns/1ps
module wr_order_router
  import wor_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 8,
  parameter int SEL_BIT = 12,
  parameter int DEPTH   = 4,
  parameter int RDEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  output logic [1:0]        m_awvalid,
  input  logic [1:0]        m_awready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [LEN_W-1:0]  m_awlen,
  output logic [1:0]        m_wvalid,
  input  logic [1:0]        m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  input  logic [1:0]        m_bvalid,
  output logic [1:0]        m_bready,
  input  logic [2*ID_W-1:0] m_bid,
  input  logic [3:0]        m_bresp
);
  localparam int NUM_ID = 1 << ID_W;

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  port_t             aw_sel;
  logic              aw_go, aw_fire, route_full, b_fire;
  logic [NUM_ID-1:0] id_full, id_empty, id_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign aw_sel  = s_awaddr[SEL_BIT];
  assign aw_go   = s_awvalid && !id_full[s_awid] && !route_full;
  assign s_awready = aw_go && m_awready[aw_sel];
  assign aw_fire = s_awvalid && s_awready;

  always_comb begin
    m_awvalid         = '0;
    m_awvalid[aw_sel] = aw_go;
  end

  assign m_awid   = s_awid;
  assign m_awaddr = s_awaddr;
  assign m_awlen  = s_awlen;
  assign m_wdata  = s_wdata;
  assign m_wlast  = s_wlast;

  for (genvar g = 0; g < NUM_ID; g++) begin : g_id
    wor_fifo #(.WIDTH(1), .DEPTH(DEPTH)) u_order (
      .clk   (clk),
      .rst_n (rst_int_n),
      .push  (aw_fire && (s_awid == ID_W'(g))),
      .pop   (b_fire && (s_bid == ID_W'(g))),
      .din   (aw_sel),
      .head  (id_head[g +: 1]),
      .full  (id_full[g]),
      .empty (id_empty[g])
    );
  end

  wor_w_router #(.RDEPTH(RDEPTH)) u_wr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .aw_push    (aw_fire),
    .aw_port    (aw_sel),
    .route_full (route_full),
    .s_wvalid   (s_wvalid),
    .s_wlast    (s_wlast),
    .s_wready   (s_wready),
    .m_wvalid   (m_wvalid),
    .m_wready   (m_wready)
  );

  wor_b_arbiter #(.ID_W(ID_W)) u_barb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .m_bvalid (m_bvalid),
    .m_bready (m_bready),
    .m_bid    (m_bid),
    .m_bresp  (m_bresp),
    .id_head  (id_head),
    .id_empty (id_empty),
    .s_bvalid (s_bvalid),
    .s_bready (s_bready),
    .s_bid    (s_bid),
    .s_bresp  (s_bresp),
    .b_fire   (b_fire)
  );

  p_decode_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    aw_fire |-> m_awvalid[aw_sel] && !m_awvalid[~aw_sel]);
  p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    s_awvalid && id_full[s_awid] |-> !s_awready);
  p_resp_known_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    s_bvalid |-> !id_empty[s_bid]);
endmodule

// File: tb/tb_wr_order_router.sv
`timescale 1ns/1ps
module tb_wr_order_router;
  typedef struct packed {
    logic [1:0] xid;
    logic [1:0] xresp;
    logic       xsrc;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        s_awvalid, s_awready, s_wvalid, s_wready, s_wlast;
  logic [1:0]  s_awid;
  logic [15:0] s_awaddr;
  logic [7:0]  s_awlen;
  logic [31:0] s_wdata;
  logic        s_bvalid, s_bready;
  logic [1:0]  s_bid, s_bresp;
  logic [1:0]  m_awvalid, m_wvalid, m_bvalid, m_bready;
  logic [1:0]  m_awid;
  logic [15:0] m_awaddr;
  logic [7:0]  m_awlen;
  logic [31:0] m_wdata;
  logic        m_wlast;
  logic [3:0]  m_bid, m_bresp;
  logic        sb_valid [2];
  logic [1:0]  sb_id [2];
  logic [1:0]  sb_resp [2];

  assign m_bvalid = {sb_valid[1], sb_valid[0]};
  assign m_bid    = {sb_id[1], sb_id[0]};
  assign m_bresp  = {sb_resp[1], sb_resp[0]};

  wr_order_router dut (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid),
    .s_awaddr(s_awaddr), .s_awlen(s_awlen),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
    .m_awvalid(m_awvalid), .m_awready(2'b11), .m_awid(m_awid),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen),
    .m_wvalid(m_wvalid), .m_wready(2'b11), .m_wdata(m_wdata), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bid(m_bid), .m_bresp(m_bresp)
  );

  int   n_chk = 0, n_bad = 0;
  exp_t exp_q[$];
  logic src_log[$];
  int   w_cnt [2];
  int   w_exp [2];
  logic mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      for (int k = 0; k < 2; k++) begin
        if (m_awvalid[k]) begin
          check(k == int'(s_awaddr[12]), "R1", "aw port", k, int'(s_awaddr[12]));
          check(m_awid == s_awid && m_awaddr == s_awaddr && m_awlen == s_awlen,
                "R1", "aw fields", int'(m_awaddr), int'(s_awaddr));
        end
        if (m_wvalid[k]) w_cnt[k]++;
      end
      if (s_bvalid && s_bready) begin
        int   hit;
        logic src;
        hit = -1;
        src = m_bready[1];
        src_log.push_back(src);
        for (int i = 0; i < exp_q.size(); i++)
          if (hit < 0 && exp_q[i].xid == s_bid) hit = i;
        check(hit >= 0, "R6", "unexpected bid", int'(s_bid), -1);
        if (hit >= 0) begin
          check(exp_q[hit].xsrc == src, "R4", "response source port",
                int'(src), int'(exp_q[hit].xsrc));
          check(exp_q[hit].xresp == s_bresp, "R6", "bresp",
                int'(s_bresp), int'(exp_q[hit].xresp));
          exp_q.delete(hit);
        end
      end
    end
  end

  task automatic do_aw(input logic [1:0] i_id, input logic [15:0] i_addr,
                       input logic [7:0] i_len, input logic [1:0] i_rsp);
    s_awvalid = 1'b1; s_awid = i_id; s_awaddr = i_addr; s_awlen = i_len;
    @(negedge clk);
    while (!s_awready) @(negedge clk);
    @(posedge clk); #1;
    s_awvalid = 1'b0;
    exp_q.push_back('{xid: i_id, xresp: i_rsp, xsrc: i_addr[12]});
    w_exp[i_addr[12]] += int'(i_len) + 1;
  endtask

  task automatic do_w(input int beats_m1);
    for (int b = 0; b <= beats_m1; b++) begin
      s_wvalid = 1'b1; s_wdata = 32'hA500 + b; s_wlast = (b == beats_m1);
      @(negedge clk);
      while (!s_wready) @(negedge clk);
      @(posedge clk); #1;
    end
    s_wvalid = 1'b0; s_wlast = 1'b0;
  endtask

  task automatic tgt_resp(input int k, input logic [1:0] i_id, input logic [1:0] i_rsp);
    sb_valid[k] = 1'b1; sb_id[k] = i_id; sb_resp[k] = i_rsp;
    @(negedge clk);
    while (!m_bready[k]) @(negedge clk);
    @(posedge clk); #1;
    sb_valid[k] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; s_awvalid = 1'b0; s_awid = '0; s_awaddr = '0; s_awlen = '0;
    s_wvalid = 1'b0; s_wdata = '0; s_wlast = 1'b0; s_bready = 1'b1;
    for (int k = 0; k < 2; k++) begin
      sb_valid[k] = 1'b0; sb_id[k] = '0; sb_resp[k] = '0; w_cnt[k] = 0; w_exp[k] = 0;
    end
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    @(negedge clk);
    // R9 reset state
    check(!s_bvalid && !s_awready && !s_wready, "R9", "upstream idle",
          int'({s_bvalid, s_awready, s_wready}), 0);
    check(m_awvalid == 0 && m_wvalid == 0 && m_bready == 0, "R9", "downstream idle",
          int'({m_awvalid, m_wvalid, m_bready}), 0);
    mon_on = 1'b1;
    @(posedge clk); #1;

    // R3: data with no accepted address is held off
    s_wvalid = 1'b1; s_wlast = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check(!s_wready && m_wvalid == 0, "R3", "data without address",
            int'({s_wready, m_wvalid}), 0);
    end
    @(posedge clk); #1;
    s_wvalid = 1'b0; s_wlast = 1'b0;

    // R4: same ID, port 1 answers first and must wait
    do_aw(2'd0, 16'h0000, 8'd1, 2'd0); do_w(1);
    do_aw(2'd0, 16'h1000, 8'd0, 2'd1); do_w(0);
    fork
      tgt_resp(1, 2'd0, 2'd1);
      begin
        repeat (3) begin
          @(negedge clk);
          check(!m_bready[1] && !s_bvalid, "R4", "early response parked",
                int'({m_bready[1], s_bvalid}), 0);
        end
        @(posedge clk); #1;
        tgt_resp(0, 2'd0, 2'd0);
      end
    join

    // R5: different IDs may overtake
    do_aw(2'd1, 16'h0010, 8'd0, 2'd2); do_w(0);
    do_aw(2'd2, 16'h1020, 8'd0, 2'd3); do_w(0);
    tgt_resp(1, 2'd2, 2'd3);
    check(exp_q.size() == 1 && exp_q[0].xid == 2'd1, "R5", "other ID passed",
          exp_q.size(), 1);
    tgt_resp(0, 2'd1, 2'd2);

    // R2: fifth outstanding write of one ID is held off
    for (int i = 0; i < 4; i++) begin
      do_aw(2'd3, 16'h0100 + 16'(i * 16), 8'd0, 2'(i)); do_w(0);
    end
    s_awvalid = 1'b1; s_awid = 2'd3; s_awaddr = 16'h1040; s_awlen = 8'd0;
    repeat (4) begin
      @(negedge clk);
      check(!s_awready, "R2", "full ID stalls address", int'(s_awready), 0);
    end
    @(posedge clk); #1;
    tgt_resp(0, 2'd3, 2'd0);
    @(negedge clk);
    check(s_awready, "R2", "address accepted after response", int'(s_awready), 1);
    @(posedge clk); #1;
    s_awvalid = 1'b0;
    exp_q.push_back('{xid: 2'd3, xresp: 2'd1, xsrc: 1'b1});
    w_exp[1] += 1;
    do_w(0);
    tgt_resp(0, 2'd3, 2'd1); tgt_resp(0, 2'd3, 2'd2); tgt_resp(0, 2'd3, 2'd3);
    tgt_resp(1, 2'd3, 2'd1);

    // R7: both ports continuously ready with a deliverable response
    do_aw(2'd0, 16'h0000, 8'd0, 2'd0); do_w(0);
    do_aw(2'd1, 16'h0010, 8'd0, 2'd1); do_w(0);
    do_aw(2'd2, 16'h1000, 8'd0, 2'd2); do_w(0);
    do_aw(2'd3, 16'h1010, 8'd0, 2'd3); do_w(0);
    src_log.delete();
    fork
      begin tgt_resp(0, 2'd0, 2'd0); tgt_resp(0, 2'd1, 2'd1); end
      begin tgt_resp(1, 2'd2, 2'd2); tgt_resp(1, 2'd3, 2'd3); end
    join
    check(src_log.size() == 4, "R7", "grant count", src_log.size(), 4);
    if (src_log.size() == 4)
      for (int i = 1; i < 4; i++)
        check(src_log[i] != src_log[i-1], "R7", "alternating grant",
              int'(src_log[i]), int'(!src_log[i-1]));

    // R8: held response stays stable while upstream stalls
    do_aw(2'd2, 16'h0020, 8'd0, 2'd2); do_w(0);
    s_bready = 1'b0;
    fork
      tgt_resp(0, 2'd2, 2'd2);
      begin
        repeat (3) begin
          @(negedge clk);
          check(s_bvalid && s_bid == 2'd2 && s_bresp == 2'd2, "R8", "held response",
                int'({s_bvalid, s_bid, s_bresp}), 5'b1_10_10);
        end
        @(posedge clk); #1;
        s_bready = 1'b1;
      end
    join

    // R3: multi-beat burst to port 1
    do_aw(2'd1, 16'h1030, 8'd2, 2'd1); do_w(2);
    tgt_resp(1, 2'd1, 2'd1);

    repeat (3) @(posedge clk);
    for (int k = 0; k < 2; k++)
      check(w_cnt[k] == w_exp[k], "R3", "beats per port", w_cnt[k], w_exp[k]);
    check(exp_q.size() == 0, "R4", "all responses delivered", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule